// File: doc/BRIEF.md
# External Interrupt Sense Controller

The block turns four external interrupt request pins into conditioned request lines. Each pin first passes through a two-flop synchronizer. Each pin then has its own 2-bit sense code, which selects an active-high level, an active-low level, a rising edge or a falling edge. In the two edge modes an edge sets a pending flag. The flag holds until software clears it by writing a one to that pin's acknowledge bit. In the level modes the request simply follows the synchronized pin.

All configuration sits in one 32-bit control word on a simple write-strobe register bus, and the word reads back at all times. A per-pin enable bit gates each request, and a master enable gates all four. A separate routing bit is brought out for the logic downstream. It tells that logic whether the request of pin 0, which feeds the critical tier, goes on the normal interrupt path. The requests of pins 1 to 3 feed the main tier. Priority encoding is done outside this block.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset the control word reads 0 and all request outputs are 0. All pins are then disabled and use active-high level sense.
- R2: The control word has the following layout, and all other bits read 0 and ignore writes.
  - The sense field of pin n is bits [23-2n:22-2n].
  - The enable bit of pin n is bit 11-n, and 1 enables the pin.
  - Bit 12 is the master enable.
  - Bit 0 is the critical routing bit.
  - A full write of all ones therefore reads back 32'h00FF1F01.
- R3: The acknowledge bit of pin n is bit 27-n. Acknowledge bits always read back as 0.
- R4: Sense code 0 selects an active-high level. The request follows the pin through two synchronizer flops. A pin value applied before clock edge k shows on the request after edge k+1, and not after edge k alone.
- R5: Sense code 3 selects an active-low level. The request is 1 while the synchronized pin is 0.
- R6: Sense code 1 selects the rising edge. A rising edge on the synchronized pin sets a pending request, which stays set after the pin falls.
- R7: Sense code 2 selects the falling edge. Only a falling edge sets the pending request, and a rising edge has no effect.
- R8: Writing 1 to a pin's acknowledge bit clears its pending edge request at that write's clock edge. An edge detected in the same cycle keeps the request set. In level modes an acknowledge has no effect on the request.
- R9: Each request output is ANDed with its enable bit and with the master enable. An edge that occurs while the output is gated still sets the pending request, which appears once the gating is lifted.
- R10: Output crit_route_o always equals control bit 0.
- R11: While a pin's sense code is a level mode, its pending edge request is held cleared. Returning to an edge mode therefore shows no stale request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | 4 | Asynchronous external interrupt pins |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Current control word; acknowledge bits read 0 |
| irq_req_o | output | 4 | Conditioned request per pin; bit 0 feeds the critical tier, bits 1 to 3 the main tier |
| crit_route_o | output | 1 | Critical routing bit: 1 sends critical requests on the normal path |

## Verification
The level assertions compare each request with the synchronized pin value inside the block. They therefore assume that the pins may change at any time, and the stimulus does change them at arbitrary negative edges with no relation to the register writes. The edge-hold assertion assumes that only a register write can drop a pending request. The stimulus accordingly mixes writes that change the mode, writes that only acknowledge, and writes that close the gating, all while pins toggle. Register writes are full-word only, so the readback assertion assumes that every strobe carries a complete word.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int NUM_PINS    = 4;
    localparam int REG_W       = 32;
    localparam int SYNC_STAGES = 2;
    localparam int SENSE_TOP   = 22;
    localparam int EN_TOP      = 11;
    localparam int ACK_TOP     = 27;
    localparam int MASTER_BIT  = 12;
    localparam int ROUTE_BIT   = 0;

    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'd0,
        SENSE_RISE   = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_LVL_LO = 2'd3
    } sense_e;

    typedef struct packed {
        logic [NUM_PINS-1:0][1:0] sense;
        logic [NUM_PINS-1:0]      en;
        logic                     master;
        logic                     route;
    } ctrl_t;

    function automatic logic is_edge_mode(input logic [1:0] code);
        return (code == SENSE_RISE) || (code == SENSE_FALL);
    endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
    import ext_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [REG_W-1:0]    wdata_i,
    output ctrl_t               ctrl_o,
    output logic [NUM_PINS-1:0] ack_o,
    output logic [REG_W-1:0]    rdata_o
);
    ctrl_t ctrl_d, ctrl_q;
    ctrl_t wr_fields;

    always_comb begin
        wr_fields        = '0;
        wr_fields.master = wdata_i[MASTER_BIT];
        wr_fields.route  = wdata_i[ROUTE_BIT];
        for (int n = 0; n < NUM_PINS; n++) begin
            wr_fields.sense[n] = wdata_i[SENSE_TOP-2*n +: 2];
            wr_fields.en[n]    = wdata_i[EN_TOP-n];
        end
        ctrl_d = wr_i ? wr_fields : ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_ack
            assign ack_o[g] = wr_i & wdata_i[ACK_TOP-g];
        end
    endgenerate

    always_comb begin
        rdata_o             = '0;
        rdata_o[MASTER_BIT] = ctrl_q.master;
        rdata_o[ROUTE_BIT]  = ctrl_q.route;
        for (int n = 0; n < NUM_PINS; n++) begin
            rdata_o[SENSE_TOP-2*n +: 2] = ctrl_q.sense[n];
            rdata_o[EN_TOP-n]           = ctrl_q.en[n];
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ext_irq_sense_cell.sv
module ext_irq_sense_cell
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s_i,
    input  logic [1:0] sense_i,
    input  logic       ack_i,
    input  logic       gate_i,
    output logic       req_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } cell_state_t;

    cell_state_t st_d, st_q;
    logic        rise, fall, hit, active;

    always_comb begin
        rise = pin_s_i & ~st_q.prev;
        fall = ~pin_s_i & st_q.prev;
        hit  = ((sense_i == SENSE_RISE) & rise) | ((sense_i == SENSE_FALL) & fall);

        st_d      = st_q;
        st_d.prev = pin_s_i;
        if (is_edge_mode(sense_i)) begin
            st_d.pend = hit | (st_q.pend & ~ack_i);
        end else begin
            st_d.pend = 1'b0;
        end

        unique case (sense_i)
            SENSE_LVL_HI: active = pin_s_i;
            SENSE_LVL_LO: active = ~pin_s_i;
            default:      active = st_q.pend;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = gate_i & active;
endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
    import ext_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_pin_i,
    input  logic                reg_wr_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o,
    output logic [NUM_PINS-1:0] irq_req_o,
    output logic                crit_route_o
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] ack;
    ctrl_t               ctrl;

    ext_irq_sync #(
        .W      (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_pin_i),
        .sync_o  (pin_sync)
    );

    ext_irq_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .ctrl_o  (ctrl),
        .ack_o   (ack),
        .rdata_o (reg_rdata_o)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_cell
            ext_irq_sense_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_s_i (pin_sync[g]),
                .sense_i (ctrl.sense[g]),
                .ack_i   (ack[g]),
                .gate_i  (ctrl.en[g] & ctrl.master),
                .req_o   (irq_req_o[g])
            );
        end
    endgenerate

    assign crit_route_o = ctrl.route;
endmodule

// File: rtl/ext_irq_sense_ctrl_chk.sv
module ext_irq_sense_ctrl_chk
    import ext_irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr_i,
    input logic [REG_W-1:0]    reg_wdata_i,
    input logic [REG_W-1:0]    reg_rdata_o,
    input logic [NUM_PINS-1:0] irq_req_o,
    input logic [NUM_PINS-1:0] pin_sync
);
    localparam logic [REG_W-1:0] RD_MASK = 32'h00FF1F01;

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> reg_rdata_o == ($past(reg_wdata_i) & RD_MASK)); // R2

    AST_MASTER_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata_o[MASTER_BIT] |-> irq_req_o == '0); // R9

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_pin
            AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
                !reg_rdata_o[EN_TOP-g] |-> !irq_req_o[g]); // R9

            AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rdata_o[SENSE_TOP-2*g +: 2] == 2'd0 && reg_rdata_o[EN_TOP-g]
                 && reg_rdata_o[MASTER_BIT]) |-> irq_req_o[g] == pin_sync[g]); // R4

            AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rdata_o[SENSE_TOP-2*g +: 2] == 2'd3 && reg_rdata_o[EN_TOP-g]
                 && reg_rdata_o[MASTER_BIT]) |-> irq_req_o[g] == !pin_sync[g]); // R5

            AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (is_edge_mode(reg_rdata_o[SENSE_TOP-2*g +: 2]) && irq_req_o[g]
                 && !reg_wr_i) |=> irq_req_o[g]); // R6
        end
    endgenerate
endmodule

bind ext_irq_sense_ctrl ext_irq_sense_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_req_o   (irq_req_o),
    .pin_sync    (pin_sync)
);

// File: tb/ext_irq_sense_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_sense_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pins = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  req;
    logic        route;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_irq_sense_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_pin_i    (pins),
        .reg_wr_i     (wr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_req_o    (req),
        .crit_route_o (route)
    );

    // Behavioural reference: pin history, pending flags and fields as integers
    int m_s1[4], m_s2[4], m_pv[4], m_pd[4], m_sense[4], m_en[4];
    int m_mst, m_rte;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 4; n++) begin
                m_s1[n] = 0; m_s2[n] = 0; m_pv[n] = 0; m_pd[n] = 0;
                m_sense[n] = 0; m_en[n] = 0;
            end
            m_mst = 0; m_rte = 0;
        end else begin
            for (int n = 0; n < 4; n++) begin
                int hit;
                hit = (m_sense[n] == 1 && m_s2[n] == 1 && m_pv[n] == 0) ||
                      (m_sense[n] == 2 && m_s2[n] == 0 && m_pv[n] == 1);
                if (m_sense[n] == 0 || m_sense[n] == 3) m_pd[n] = 0;
                else if (hit) m_pd[n] = 1;
                else if (wr && wdata[27-n]) m_pd[n] = 0;
                m_pv[n] = m_s2[n];
                m_s2[n] = m_s1[n];
                m_s1[n] = pins[n];
            end
            if (wr) begin
                for (int n = 0; n < 4; n++) begin
                    m_sense[n] = (wdata >> (22 - 2*n)) & 3;
                    m_en[n]    = wdata[11-n];
                end
                m_mst = wdata[12];
                m_rte = wdata[0];
            end
        end
    end

    function automatic logic [3:0] model_req();
        logic [3:0] r;
        for (int n = 0; n < 4; n++) begin
            int act;
            case (m_sense[n])
                0: act = m_s2[n];
                3: act = !m_s2[n];
                default: act = m_pd[n];
            endcase
            r[n] = (m_mst != 0) && (m_en[n] != 0) && (act != 0);
        end
        return r;
    endfunction

    function automatic logic [31:0] model_rd();
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v = v | (32'(m_sense[n]) << (22 - 2*n));
            v[11-n] = m_en[n][0];
        end
        v[12] = m_mst[0];
        v[0]  = m_rte[0];
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (req !== model_req()) begin
                fails++;
                $display("FAIL MODEL(R6) req actual=%b expected=%b", req, model_req());
            end
            tests++;
            if (rdata !== model_rd() || route !== m_rte[0]) begin
                fails++;
                $display("FAIL MODEL(R2) rdata actual=%h expected=%h", rdata, model_rd());
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [31:0] d);
        wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        check("R1 rdata", rdata, 32'h0);
        check("R1 req", {28'h0, req}, 32'h0);

        wr_reg(32'hFFFF_FFFF);
        check("R2 readback", rdata, 32'h00FF1F01);
        check("R3 ack bits", {28'h0, rdata[27:24]}, 32'h0);
        wr_reg(32'h0);

        // level high on all pins
        wr_reg(32'h0000_1F00);
        pins[0] = 1'b1;
        cyc(1);
        check("R4 one edge", {31'h0, req[0]}, 32'h0);
        cyc(1);
        check("R4 two edges", {31'h0, req[0]}, 32'h1);
        wr_reg(32'h0000_1F00 | (32'h1 << 27));
        check("R8 level ack ignored", {31'h0, req[0]}, 32'h1);
        pins[0] = 1'b0;
        cyc(3);

        // active low on pin 1
        wr_reg(32'h0030_1F00);
        cyc(2);
        check("R5 low active", {31'h0, req[1]}, 32'h1);
        pins[1] = 1'b1;
        cyc(2);
        check("R5 high idle", {31'h0, req[1]}, 32'h0);

        // rising edge on pin 2
        wr_reg(32'h0034_1F00);
        pins[2] = 1'b1; cyc(1); pins[2] = 1'b0;
        cyc(4);
        check("R6 latched", {31'h0, req[2]}, 32'h1);
        cyc(5);
        check("R6 held", {31'h0, req[2]}, 32'h1);
        wr_reg(32'h0034_1F00 | (32'h1 << 25));
        check("R8 ack clears", {31'h0, req[2]}, 32'h0);

        // falling edge on pin 3
        wr_reg(32'h0036_1F00);
        pins[3] = 1'b1;
        cyc(4);
        check("R7 rise ignored", {31'h0, req[3]}, 32'h0);
        pins[3] = 1'b0;
        cyc(4);
        check("R7 fall latched", {31'h0, req[3]}, 32'h1);
        wr_reg(32'h0036_1F00 | (32'h1 << 24));
        check("R8 ack pin3", {31'h0, req[3]}, 32'h0);

        // master gating with an edge occurring while gated
        wr_reg(32'h0036_0F00);
        pins[1] = 1'b0;
        pins[2] = 1'b1; cyc(1); pins[2] = 1'b0;
        cyc(4);
        check("R9 master off", {28'h0, req}, 32'h0);
        wr_reg(32'h0036_1F00);
        check("R9 pend kept", {31'h0, req[2]}, 32'h1);
        check("R9 level pin1", {31'h0, req[1]}, 32'h1);
        wr_reg(32'h0036_1B00);
        check("R9 enable off", {31'h0, req[1]}, 32'h0);

        // level mode clears a stale pending flag
        wr_reg(32'h0030_1F00);
        cyc(2);
        wr_reg(32'h0034_1F00);
        check("R11 no stale", {31'h0, req[2]}, 32'h0);

        // routing bit
        wr_reg(32'h0000_1F01);
        check("R10 route set", {31'h0, route}, 32'h1);
        wr_reg(32'h0000_1F00);
        check("R10 route clear", {31'h0, route}, 32'h0);

        cyc(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule